// File: doc/BRIEF.md
# Side-Bit Inserting Byte-to-Quintet Packer

The block sits between the interleave buffer reader and the 5/6 modulation coder of a helical-track recorder. It takes the 128 bytes of one data block as a byte stream and repacks them into 5-bit symbols. Each byte is taken most significant bit first, and each symbol is filled most significant bit first. The 1024 data bits make 204 whole symbols with four bits left over. The block then adds one extra bit, the side bit, to close symbol 205. Every data block therefore leaves as exactly 205 symbols, and the last one is flagged.

The side bit depends on the position of the data block within its track. On the first track of a principal block, the side bits of successive data blocks spell out several values, each least significant bit first: three identical copies of the 20-bit principal block number, a 16-bit volume label, a fixed 4-bit revision code, and two one-bit flags. Every other side bit is zero, and so is every side bit on the other tracks. A track-start pulse restarts the block numbering and records whether the new track is the first of its principal block. The values to be spread are read from level inputs that the system holds steady for the whole track.

Top module: `misc_bit_packer`

## Requirements
- R1: The 128 bytes of a data block leave as 205 symbols (`outSym` bit 4 sent first). Bytes enter MSB first. Symbol 205 holds the last four data bits in bits 4..1 and the side bit in bit 0.
- R2: `outLast` is high with the 205th symbol of each data block and with no other symbol.
- R3: On a first track, data blocks 1–20, 21–40 and 41–60 each carry the 20-bit `pbNum` in their side bits, with bit 0 in the lowest-numbered data block of each group.
- R4: On a first track, data blocks 61–76 carry `volLabel`, with bit 0 in data block 61.
- R5: On a first track, data blocks 77–80 carry the revision code 0001 LSB first, so data block 77 has side bit 1 and data blocks 78–80 have 0.
- R6: On a first track, data block 81 carries `mixedFlag` and data block 82 carries `sizeFlag`.
- R7: On a first track, the side bit is 0 for data block 83 and for every later data block.
- R8: On a track marked not-first, every side bit is 0, whatever the other inputs hold.
- R9: A `trackStart` pulse, given between data blocks, makes the next data block number 1 and samples `firstTrackIn` for the whole track.
- R10: While `outValid` is high and `outReady` is low, `inReady` is low and `outSym` holds its value until accepted.
- R11: During and right after reset, `outValid` and `outLast` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| trackStart | input | 1 | One-cycle pulse between data blocks: restart block numbering |
| firstTrackIn | input | 1 | Sampled with `trackStart`: 1 if the new track is the first of its principal block |
| pbNum | input | 20 | Principal block number, two's complement |
| volLabel | input | 16 | Volume label |
| mixedFlag | input | 1 | Mixed-input flag, sent in data block 81 |
| sizeFlag | input | 1 | Cartridge-size flag, sent in data block 82 |
| inData | input | 8 | Byte from the interleave buffer |
| inValid | input | 1 | `inData` is valid |
| inReady | output | 1 | Byte is taken at the rising edge when `inValid` is also high |
| outSym | output | 5 | 5-bit symbol to the modulation coder |
| outValid | output | 1 | `outSym` is valid |
| outReady | input | 1 | Coder takes `outSym` at this rising edge |
| outLast | output | 1 | Marks symbol 205 of a data block |

## Verification
`inReady` is a combinational function of the registered bit count and of `outReady` in the same cycle. A byte taken at a rising edge can therefore appear in `outSym` from that edge on, with no extra register stage, and the side bit appears in the symbol that completes right after the 128th byte. The bench drives all inputs on the falling edge and waits one nanosecond. It then reads `inReady`, `outValid`, `outSym` and `outLast` before the next rising edge and counts a transfer wherever that edge will complete a handshake. Side bits are compared with a model of R3 to R8, keyed by the data block number that the bench itself counts from the last `trackStart` pulse.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;

  localparam int unsigned PB_W      = 20;
  localparam int unsigned VOL_W     = 16;
  localparam int unsigned REV_W     = 4;
  localparam logic [REV_W-1:0] REV_CODE = 4'b0001;
  localparam int unsigned COPIES    = 3;

  // data block numbers (1-based) of each side-bit field on a first track
  localparam int unsigned COPY_END  = COPIES * PB_W;
  localparam int unsigned VOL_FIRST = COPY_END + 1;
  localparam int unsigned VOL_LAST  = COPY_END + VOL_W;
  localparam int unsigned REV_FIRST = VOL_LAST + 1;
  localparam int unsigned REV_LAST  = VOL_LAST + REV_W;
  localparam int unsigned MIX_BLK   = REV_LAST + 1;
  localparam int unsigned SIZE_BLK  = REV_LAST + 2;

  typedef enum logic [1:0] {PH_BYTES, PH_SIDE, PH_DRAIN} phase_t;

  typedef struct packed {
    logic loadByte;
    logic loadSide;
    logic emit;
    logic sideBit;
  } strobe_t;

  function automatic logic pickSide(input int unsigned blk,
                                    input logic [PB_W-1:0] pb,
                                    input logic [VOL_W-1:0] vol,
                                    input logic mixed,
                                    input logic size);
    logic [PB_W-1:0]  pbSh;
    logic [VOL_W-1:0] volSh;
    logic [REV_W-1:0] revSh;
    logic b;
    pbSh  = '0;
    volSh = '0;
    revSh = '0;
    b     = 1'b0;
    if (blk >= 1 && blk <= COPY_END) begin
      pbSh = pb >> ((blk - 1) % PB_W);
      b    = pbSh[0];
    end else if (blk >= VOL_FIRST && blk <= VOL_LAST) begin
      volSh = vol >> (blk - VOL_FIRST);
      b     = volSh[0];
    end else if (blk >= REV_FIRST && blk <= REV_LAST) begin
      revSh = REV_CODE >> (blk - REV_FIRST);
      b     = revSh[0];
    end else if (blk == MIX_BLK) begin
      b = mixed;
    end else if (blk == SIZE_BLK) begin
      b = size;
    end
    return b;
  endfunction

endpackage

// File: rtl/bitpack_dp.sv
module bitpack_dp
  import bitpack_pkg::*;
#(
  parameter int SYM_W  = 5,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = BYTE_W + SYM_W,
  parameter int CNT_W  = $clog2(ACC_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [BYTE_W-1:0] inData,
  output logic [CNT_W-1:0]  cnt,
  output logic              outValid,
  output logic [SYM_W-1:0]  outSym
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [CNT_W-1:0] cntNext;
  logic [ACC_W-1:0] accView;

  always_comb begin
    accNext = acc;
    if (strobe.loadByte)
      accNext = {acc[ACC_W-BYTE_W-1:0], inData};
    else if (strobe.loadSide)
      accNext = {acc[ACC_W-2:0], strobe.sideBit};
  end

  always_comb begin
    cntNext = cnt;
    if (strobe.emit)     cntNext = cntNext - CNT_W'(SYM_W);
    if (strobe.loadByte) cntNext = cntNext + CNT_W'(BYTE_W);
    if (strobe.loadSide) cntNext = cntNext + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= accNext;
      cnt <= cntNext;
    end
  end

  // oldest unsent bits sit at positions cnt-1 down to cnt-SYM_W
  assign accView  = acc >> (cnt - CNT_W'(SYM_W));
  assign outSym   = accView[SYM_W-1:0];
  assign outValid = (cnt >= CNT_W'(SYM_W));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(ACC_W)); // R10

  AST_HOLD_SYM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !strobe.emit) |=> (outValid && $stable(outSym))); // R10

  AST_EMIT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> outValid); // R1

endmodule

// File: rtl/bitpack_ctrl.sv
module bitpack_ctrl
  import bitpack_pkg::*;
#(
  parameter int BYTES_PER_BLK = 128,
  parameter int SYM_W         = 5,
  parameter int MAX_BLOCKS    = 276,
  parameter int CNT_W         = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trackStart,
  input  logic             firstTrackIn,
  input  logic [PB_W-1:0]  pbNum,
  input  logic [VOL_W-1:0] volLabel,
  input  logic             mixedFlag,
  input  logic             sizeFlag,
  input  logic             inValid,
  output logic             inReady,
  input  logic             outReady,
  output logic             outLast,
  input  logic [CNT_W-1:0] cnt,
  output strobe_t          strobe
);

  localparam int BYTE_CNT_W = $clog2(BYTES_PER_BLK);
  localparam int BLK_W      = $clog2(MAX_BLOCKS + 1);
  localparam logic [BYTE_CNT_W-1:0] LAST_BYTE = BYTE_CNT_W'(BYTES_PER_BLK - 1);

  phase_t                phase;
  logic [BYTE_CNT_W-1:0] byteCnt;
  logic [BLK_W-1:0]      blockNum;
  logic                  firstTrack;
  logic                  room;
  logic                  symReady;

  always_comb begin
    symReady = (cnt >= CNT_W'(SYM_W));
    // room: at most SYM_W-1 bits remain after this cycle's emission
    room = (cnt < CNT_W'(SYM_W)) || ((cnt < CNT_W'(2 * SYM_W)) && outReady);
    inReady = (phase == PH_BYTES) && room;
    strobe.emit     = symReady && outReady;
    strobe.loadByte = inValid && inReady;
    strobe.loadSide = (phase == PH_SIDE) && room;
    strobe.sideBit  = firstTrack &
                      pickSide(32'(blockNum), pbNum, volLabel, mixedFlag, sizeFlag);
    outLast = (phase == PH_DRAIN) && symReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_BYTES;
      byteCnt <= '0;
    end else begin
      case (phase)
        PH_BYTES:
          if (strobe.loadByte) begin
            if (byteCnt == LAST_BYTE) begin
              byteCnt <= '0;
              phase   <= PH_SIDE;
            end else begin
              byteCnt <= byteCnt + BYTE_CNT_W'(1);
            end
          end
        PH_SIDE:
          if (strobe.loadSide) phase <= PH_DRAIN;
        PH_DRAIN:
          if (strobe.emit) phase <= PH_BYTES;
        default:
          phase <= PH_BYTES;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockNum   <= BLK_W'(1);
      firstTrack <= 1'b0;
    end else if (trackStart) begin
      blockNum   <= BLK_W'(1);
      firstTrack <= firstTrackIn;
    end else if (outLast && outReady) begin
      blockNum   <= blockNum + BLK_W'(1);
    end
  end

  AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && outReady) |=> !outLast); // R2

  AST_BLOCK_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && outReady && !trackStart) |=> (blockNum == $past(blockNum) + BLK_W'(1))); // R2

  AST_TRACK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    trackStart |=> (blockNum == BLK_W'(1) && firstTrack == $past(firstTrackIn))); // R9

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (symReady && !outReady) |-> !inReady); // R10

endmodule

// File: rtl/misc_bit_packer.sv
module misc_bit_packer
  import bitpack_pkg::*;
#(
  parameter int BYTES_PER_BLK = 128,
  parameter int SYM_W         = 5,
  parameter int BYTE_W        = 8,
  parameter int MAX_BLOCKS    = 276
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trackStart,
  input  logic              firstTrackIn,
  input  logic [19:0]       pbNum,
  input  logic [15:0]       volLabel,
  input  logic              mixedFlag,
  input  logic              sizeFlag,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [4:0]        outSym,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast
);

  localparam int ACC_W = BYTE_W + SYM_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  strobe_t          strobe;
  logic [CNT_W-1:0] cnt;

  bitpack_ctrl #(
    .BYTES_PER_BLK(BYTES_PER_BLK),
    .SYM_W        (SYM_W),
    .MAX_BLOCKS   (MAX_BLOCKS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .trackStart  (trackStart),
    .firstTrackIn(firstTrackIn),
    .pbNum       (pbNum),
    .volLabel    (volLabel),
    .mixedFlag   (mixedFlag),
    .sizeFlag    (sizeFlag),
    .inValid     (inValid),
    .inReady     (inReady),
    .outReady    (outReady),
    .outLast     (outLast),
    .cnt         (cnt),
    .strobe      (strobe)
  );

  bitpack_dp #(
    .SYM_W (SYM_W),
    .BYTE_W(BYTE_W),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .cnt     (cnt),
    .outValid(outValid),
    .outSym  (outSym)
  );

endmodule

// File: tb/misc_bit_packer_test.sv
module misc_bit_packer_test;

  localparam int NBYTES = 128;
  localparam int NSYM   = 205;

  logic        clk = 1'b0;
  logic        rstN;
  logic        trackStart;
  logic        firstTrackIn;
  logic [19:0] pbNum;
  logic [15:0] volLabel;
  logic        mixedFlag;
  logic        sizeFlag;
  logic [7:0]  inData;
  logic        inValid;
  logic        inReady;
  logic [4:0]  outSym;
  logic        outValid;
  logic        outReady;
  logic        outLast;

  always #4 clk = ~clk;

  misc_bit_packer uut (
    .clk(clk), .rstN(rstN), .trackStart(trackStart), .firstTrackIn(firstTrackIn),
    .pbNum(pbNum), .volLabel(volLabel), .mixedFlag(mixedFlag), .sizeFlag(sizeFlag),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outSym(outSym), .outValid(outValid), .outReady(outReady), .outLast(outLast)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int symErr, lastErr, stallErr;
  bit sideSeen [1:100];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] genByte(int blk, int idx, int seed);
    return 8'((blk * 37 + idx * 11 + seed * 101) ^ (idx >> 3));
  endfunction

  function automatic bit refSide(int blk, bit first);
    if (!first) return 1'b0;
    if (blk >= 1 && blk <= 20)  return pbNum[blk - 1];
    if (blk >= 21 && blk <= 40) return pbNum[blk - 21];
    if (blk >= 41 && blk <= 60) return pbNum[blk - 41];
    if (blk >= 61 && blk <= 76) return volLabel[blk - 61];
    if (blk == 77) return 1'b1;
    if (blk >= 78 && blk <= 80) return 1'b0;
    if (blk == 81) return mixedFlag;
    if (blk == 82) return sizeFlag;
    return 1'b0;
  endfunction

  // entered and left at a falling edge
  task automatic runBlock(input int blk, input bit first, input int seed,
                          input bit bp, output bit side);
    logic [7:0] bytes [NBYTES];
    bit         bits  [NBYTES*8+1];
    logic [4:0] exp   [NSYM];
    int idx = 0;
    int k   = 0;
    side = 1'b0;
    for (int i = 0; i < NBYTES; i++) begin
      bytes[i] = genByte(blk, i, seed);
      for (int j = 0; j < 8; j++) bits[i*8 + j] = bytes[i][7-j];
    end
    bits[NBYTES*8] = refSide(blk, first);
    for (int s = 0; s < NSYM; s++)
      for (int j = 0; j < 5; j++) exp[s][4-j] = bits[s*5 + j];
    while (k < NSYM) begin
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      inValid  = (idx < NBYTES) && (!bp || lfsr[5] || lfsr[7]);
      inData   = (idx < NBYTES) ? bytes[idx] : 8'h00;
      #1;
      if (outValid && !outReady && inReady) stallErr++;
      if (outValid && outReady) begin
        if (outSym !== exp[k]) begin
          if (symErr == 0)
            $display("  mismatch block %0d symbol %0d got %h want %h", blk, k, outSym, exp[k]);
          symErr++;
        end
        if (outLast !== (k == NSYM - 1)) lastErr++;
        if (k == NSYM - 1) side = outSym[0];
        k++;
      end
      if (inValid && inReady) idx++;
      @(negedge clk);
    end
    inValid  = 1'b0;
    outReady = 1'b1;
  endtask

  task automatic startTrack(input bit first);
    trackStart   = 1'b1;
    firstTrackIn = first;
    @(negedge clk);
    trackStart   = 1'b0;
  endtask

  task automatic clearStreamCounts();
    symErr = 0; lastErr = 0; stallErr = 0;
  endtask

  task automatic checkStream(input string name);
    check(symErr == 0,   "R1",  {name, " symbol mismatches"}, symErr, 0);
    check(lastErr == 0,  "R2",  {name, " last-flag errors"}, lastErr, 0);
    check(stallErr == 0, "R10", {name, " input taken while output stalled"}, stallErr, 0);
  endtask

  task automatic checkCopies(input string name);
    for (int c = 0; c < 3; c++) begin
      logic [19:0] v;
      for (int i = 0; i < 20; i++) v[i] = sideSeen[c*20 + i + 1];
      check(v === pbNum, "R3", $sformatf("%s block number copy %0d", name, c), v, pbNum);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; trackStart = 1'b0; firstTrackIn = 1'b0;
    inValid = 1'b0; inData = 8'h00; outReady = 1'b1;
    pbNum = '0; volLabel = '0; mixedFlag = 1'b0; sizeFlag = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R11", "outValid in reset", outValid, 0);
    check(outLast === 1'b0,  "R11", "outLast in reset", outLast, 0);
    check(inReady === 1'b1,  "R11", "inReady in reset", inReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R11", "state after reset",
          {outValid, inReady}, 1);
  endtask

  task automatic testFirstTrack();
    bit s;
    pbNum = 20'hFFFFB; volLabel = 16'hC35A; mixedFlag = 1'b1; sizeFlag = 1'b0;
    clearStreamCounts();
    startTrack(1'b1);
    for (int b = 1; b <= 90; b++) begin
      runBlock(b, 1'b1, 3, 1'b0, s);
      sideSeen[b] = s;
    end
    checkStream("first track");
    checkCopies("first track");
    begin
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = sideSeen[61 + i];
      check(v === volLabel, "R4", "volume label", v, volLabel);
    end
    check({sideSeen[80], sideSeen[79], sideSeen[78], sideSeen[77]} === 4'b0001, "R5",
          "revision code", {sideSeen[80], sideSeen[79], sideSeen[78], sideSeen[77]}, 1);
    check(sideSeen[81] == mixedFlag, "R6", "mixed flag bit", sideSeen[81], mixedFlag);
    check(sideSeen[82] == sizeFlag,  "R6", "size flag bit", sideSeen[82], sizeFlag);
    begin
      int ones = 0;
      for (int b = 83; b <= 90; b++) ones += sideSeen[b];
      check(ones == 0, "R7", "reserved side bits set", ones, 0);
    end
  endtask

  task automatic testOtherTrack();
    bit s;
    int ones = 0;
    pbNum = 20'hFFFFF; volLabel = 16'hFFFF; mixedFlag = 1'b1; sizeFlag = 1'b1;
    clearStreamCounts();
    startTrack(1'b0);
    for (int b = 1; b <= 4; b++) begin
      runBlock(b, 1'b0, 7, 1'b1, s);
      ones += s;
    end
    checkStream("other track");
    check(ones == 0, "R8", "side bits set on non-first track", ones, 0);
  endtask

  task automatic testBackpressure();
    bit s;
    pbNum = 20'h5A0C1; volLabel = 16'h0F0F; mixedFlag = 1'b0; sizeFlag = 1'b1;
    clearStreamCounts();
    startTrack(1'b1);
    for (int b = 1; b <= 82; b++) begin
      runBlock(b, 1'b1, 11, 1'b1, s);
      sideSeen[b] = s;
    end
    checkStream("backpressure");
    checkCopies("backpressure");
    check(sideSeen[81] == mixedFlag, "R6", "mixed flag under stalls", sideSeen[81], mixedFlag);
    check(sideSeen[82] == sizeFlag,  "R6", "size flag under stalls", sideSeen[82], sizeFlag);
  endtask

  task automatic testRestart();
    bit s1, s2, s3, s4;
    pbNum = 20'h00001; volLabel = 16'h0000; mixedFlag = 1'b0; sizeFlag = 1'b0;
    clearStreamCounts();
    startTrack(1'b1);
    runBlock(1, 1'b1, 5, 1'b0, s1);
    runBlock(2, 1'b1, 5, 1'b0, s2);
    runBlock(3, 1'b1, 5, 1'b0, s3);
    startTrack(1'b1);
    runBlock(1, 1'b1, 9, 1'b0, s4);
    checkStream("restart");
    check(s1 == 1'b1 && s2 == 1'b0 && s3 == 1'b0, "R9", "side bits before restart",
          {s1, s2, s3}, 3'b100);
    check(s4 == 1'b1, "R9", "side bit of block 1 after restart", s4, 1);
  endtask

  initial begin
    testReset();
    testFirstTrack();
    testOtherTrack();
    testBackpressure();
    testRestart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule